// File: doc/BRIEF.md
# Interrupt Flag Set/Clear/Enable Unit

This block is the interrupt bookkeeping slice of a two-wire serial bus controller. It keeps one pending flag and one enable bit for each of seventeen event sources, and exposes them through a 32-bit register interface. Writes are single-cycle: address, data and write strobe are sampled on a rising clock edge. Read data is a combinational function of the address. Register state is updated on the same edge as the write.

Each cycle the peripheral datapath presents a vector of one-cycle event pulses. A pulse on an enabled source latches its flag. Software can set flags through a write-1-to-set alias and clear them through a write-1-to-clear alias. It grows the enable set through the enable register. A write to the enable register also discards every pending flag whose bit is 0 in the written value. The single level-sensitive interrupt line is high while any source is both pending and enabled.

The block has no sequencing state. The style's state machine is replaced by one flag/enable cell per source, built by a generate loop.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset the flag register and the enable register read 0 and `irq_o` is low.
- R2: An event pulse on `evt_i[k]` sets flag k at the next rising edge only if enable bit k was set before that edge. Otherwise it has no effect.
- R3: A write to the set alias (offset 0x04) sets flag k for every written 1 in bit k whose enable bit is already set. Written 1s on disabled sources are dropped.
- R4: A write to the clear alias (offset 0x08) clears flag k for every written 1 in bit k whose enable bit is set. Other flags keep their value.
- R5: A write to the enable register (offset 0x0C) ORs the written bits into the enable bits. Enable bits are cleared only by reset.
- R6: A write to the enable register also ANDs the flag register with the written value, so flags for sources written as 0 are discarded.
- R7: `irq_o` equals the OR over k of (flag k AND enable k). It follows the register state within the same cycle as the edge that changed it.
- R8: When an enabled event pulse and a clear-alias write name the same bit in the same cycle, the flag ends up set. The same holds when an event coincides with an enable write that names the bit as 0.
- R9: Reading offset 0x00 returns the flags and reading 0x0C returns the enables. The set and clear aliases and any other offset read 0. Writes to 0x00 or to undecoded offsets change nothing.
- R10: Bits 31 to 17 of every register read 0, and written values in those bits are ignored.
- R11: Source bit positions in every register are as follows: 0 start, 1 repeated start, 2 address match, 3 transfer done, 4 TX buffer room, 5 RX data ready, 6 ACK received, 7 NACK received, 8 host stop, 9 arbitration lost, 10 bus fault, 11 bus stall, 12 TX overflow, 13 RX underflow, 14 idle timeout, 15 clock-low timeout, 16 device stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC (17) | One-cycle event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (8) | Register byte offset |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets these corner cases:

- Events and set-alias writes on sources that are not yet enabled. A design that ignored the enable gate would latch flags and raise the interrupt with nothing enabled.
- An enable write naming only new sources. A design that only ORed the enables would leave stale flags pending and keep `irq_o` high.
- A clear write and an event on the same bit in one cycle. A design where clear won would lose the event.
- Writes of all ones to the aliases and the enable register, which probe the ignored upper bits.
- Writes to the read-only flag offset, which a sloppy decoder might turn into a load.

Random traffic mixing all offsets, with a mid-run reset, covers the interactions between these cases.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Source positions inside every register (R11)
    typedef enum int unsigned {
        SRC_START        = 0,
        SRC_RESTART      = 1,
        SRC_ADDR_MATCH   = 2,
        SRC_XFER_DONE    = 3,
        SRC_TX_ROOM      = 4,
        SRC_RX_READY     = 5,
        SRC_ACK_IN       = 6,
        SRC_NACK_IN      = 7,
        SRC_HOST_STOP    = 8,
        SRC_ARB_LOSS     = 9,
        SRC_BUS_FAULT    = 10,
        SRC_BUS_STALL    = 11,
        SRC_TX_OVER      = 12,
        SRC_RX_UNDER     = 13,
        SRC_IDLE_TMO     = 14,
        SRC_SCL_LOW_TMO  = 15,
        SRC_DEV_STOP     = 16
    } irqc_src_e;

    localparam int unsigned IRQC_NUM_SRC = int'(SRC_DEV_STOP) + 1;
    localparam int unsigned IRQC_DATA_W  = 32;
    localparam int unsigned IRQC_ADDR_W  = 8;

    // Register byte offsets
    localparam int unsigned OFS_FLAG = 'h00;
    localparam int unsigned OFS_SET  = 'h04;
    localparam int unsigned OFS_CLR  = 'h08;
    localparam int unsigned OFS_EN   = 'h0C;

    typedef struct packed {
        logic set;
        logic clr;
        logic en;
    } irqc_wr_t;

    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_FLAG = 2'd1,
        RD_EN   = 2'd2
    } irqc_rdsel_e;

endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = IRQC_ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output irqc_wr_t          wr_stb_o,
    output irqc_rdsel_e       rd_sel_o
);

    logic hit_flag, hit_set, hit_clr, hit_en;

    always_comb begin
        hit_flag = (addr_i == ADDR_W'(OFS_FLAG));
        hit_set  = (addr_i == ADDR_W'(OFS_SET));
        hit_clr  = (addr_i == ADDR_W'(OFS_CLR));
        hit_en   = (addr_i == ADDR_W'(OFS_EN));
    end

    // Flag offset is read-only: no write strobe is produced for it (R9)
    always_comb begin
        wr_stb_o.set = wr_i & hit_set;
        wr_stb_o.clr = wr_i & hit_clr;
        wr_stb_o.en  = wr_i & hit_en;
    end

    always_comb begin
        if (hit_flag)      rd_sel_o = RD_FLAG;
        else if (hit_en)   rd_sel_o = RD_EN;
        else               rd_sel_o = RD_ZERO;
    end

    assert_one_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(wr_stb_o));

    assert_no_strobe_on_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |-> (wr_stb_o == '0));

    assert_flag_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADDR_W'(OFS_FLAG)) |-> (wr_stb_o == '0));

endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
    import irqc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     evt_i,
    input  irqc_wr_t wr_stb_i,
    input  logic     wbit_i,
    output logic     flag_o,
    output logic     en_o
);

    logic flag_q, en_q;
    logic flag_kept, flag_cleared, set_req, flag_d, en_d;

    // Order of effects: enable-write mask, then clear, then set (set wins, R8)
    always_comb begin
        flag_kept    = wr_stb_i.en ? (flag_q & wbit_i) : flag_q;
        flag_cleared = (wr_stb_i.clr & wbit_i & en_q) ? 1'b0 : flag_kept;
        set_req      = (evt_i | (wr_stb_i.set & wbit_i)) & en_q;
        flag_d       = flag_cleared | set_req;
        en_d         = en_q | (wr_stb_i.en & wbit_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            flag_q <= flag_d;
            en_q   <= en_d;
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;

    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i && en_o) |=> flag_o);

    assert_clear_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stb_i.clr && wbit_i && en_o && !evt_i) |=> !flag_o);

    assert_enable_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |=> en_o);

    assert_enable_write_masks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stb_i.en && !wbit_i && !(evt_i && en_o)) |=> !flag_o);

    assert_disabled_never_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_o && !flag_o) |=> !flag_o);

endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W  = IRQC_DATA_W,
    parameter int unsigned NUM_SRC = IRQC_NUM_SRC
) (
    input  irqc_rdsel_e        sel_i,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [DATA_W-1:0]  rdata_o
);

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            RD_FLAG: rdata_o[NUM_SRC-1:0] = flag_i;
            RD_EN:   rdata_o[NUM_SRC-1:0] = en_i;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W  = IRQC_DATA_W,
    parameter int unsigned ADDR_W  = IRQC_ADDR_W,
    parameter int unsigned NUM_SRC = IRQC_NUM_SRC
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    localparam int unsigned HI_W = DATA_W - NUM_SRC;

    irqc_wr_t           wr_stb;
    irqc_rdsel_e        rd_sel;
    logic [NUM_SRC-1:0] flag_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [HI_W-1:0]    unused_wdata_hi;

    // Upper write bits have no storage (R10)
    assign unused_wdata_hi = reg_wdata_i[DATA_W-1:NUM_SRC];

    irqc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wr_stb_o (wr_stb),
        .rd_sel_o (rd_sel)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        irqc_src_cell u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .evt_i    (evt_i[k]),
            .wr_stb_i (wr_stb),
            .wbit_i   (reg_wdata_i[k]),
            .flag_o   (flag_vec[k]),
            .en_o     (en_vec[k])
        );
    end

    irqc_rd_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_rd (
        .sel_i   (rd_sel),
        .flag_i  (flag_vec),
        .en_i    (en_vec),
        .rdata_o (reg_rdata_o)
    );

    assign irq_o = |(flag_vec & en_vec);

    assert_flag_within_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_vec & ~en_vec) == '0);

    assert_irq_needs_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flag_vec != '0));

    assert_upper_bits_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[DATA_W-1:NUM_SRC] == '0);

    assert_alias_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == ADDR_W'(OFS_SET) || reg_addr_i == ADDR_W'(OFS_CLR))
            |-> (reg_rdata_o == '0));

endmodule

// File: tb/test_irq_flag_unit.sv
`timescale 1ns/1ps
module test_irq_flag_unit;

    localparam int NS = 17;
    localparam logic [31:0] MASK = 32'h0001_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic          wr = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference state
    bit [31:0] m_flag = 0;
    bit [31:0] m_en = 0;

    always #2 clk = ~clk;

    irq_flag_unit i_irq_flag_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .evt_i       (evt),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic bit [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_flag;
            8'h0C:   return m_en;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock with given stimulus; model updated after the edge; compare at negedge
    task automatic cycle(input bit w, input logic [7:0] a, input logic [31:0] d,
                         input logic [NS-1:0] e, input string req);
        bit [31:0] wm, ev;
        wr = w; addr = a; wdata = d; evt = e;
        @(posedge clk);
        wm = d & MASK;
        ev = 32'(e);
        if (w && a == 8'h0C) m_flag = m_flag & wm;
        if (w && a == 8'h08) m_flag = m_flag & ~(wm & m_en);
        m_flag = m_flag | ((ev | ((w && a == 8'h04) ? wm : 32'h0)) & m_en);
        if (w && a == 8'h0C) m_en = m_en | wm;
        @(negedge clk);
        check({req, "/R7 irq"}, {31'b0, irq}, {31'b0, |(m_flag & m_en)});
        check({req, "/R10 rdata"}, rdata, model_read(a));
        wr = 1'b0; evt = '0;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        wr = 1'b0; evt = '0; addr = a;
        #1;
        check(req, rdata, exp);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr = 1'b0; evt = '0;
        m_flag = 0; m_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        read_chk(8'h00, 32'h0, "R1 flag after reset");
        read_chk(8'h0C, 32'h0, "R1 enable after reset");
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2 events ignored while disabled
        cycle(0, 8'h00, 0, '1, "R2 disabled events");
        read_chk(8'h00, 32'h0, "R2 no flag while disabled");
        // R3 set alias dropped while disabled
        cycle(1, 8'h04, 32'hFFFF_FFFF, '0, "R3 set disabled");
        read_chk(8'h00, 32'h0, "R3 no flag via alias while disabled");

        // R5 enable low nibble, R2 events latch only there
        cycle(1, 8'h0C, 32'h0000_000F, '0, "R5 enable write");
        read_chk(8'h0C, 32'h0000_000F, "R5 enable readback");
        cycle(0, 8'h00, 0, '1, "R2 enabled events");
        read_chk(8'h00, 32'h0000_000F, "R2 flags only on enabled");
        check("R7 irq high", {31'b0, irq}, 32'h1);

        // R4 clear alias
        cycle(1, 8'h08, 32'h0000_0003, '0, "R4 clear");
        read_chk(8'h00, 32'h0000_000C, "R4 clear low bits");
        cycle(1, 8'h08, 32'h0003_0000, '0, "R4 clear disabled");
        read_chk(8'h00, 32'h0000_000C, "R4 clear of disabled no effect");

        // R6 enable write discards unnamed flags
        cycle(1, 8'h0C, 32'h0000_0100, '0, "R6 enable mask");
        read_chk(8'h00, 32'h0, "R6 flags discarded");
        read_chk(8'h0C, 32'h0000_010F, "R5 enable ORed");
        check("R7 irq low", {31'b0, irq}, 32'h0);

        // R3 set alias now effective
        cycle(1, 8'h04, 32'hFFFF_FFFF, '0, "R3 set enabled");
        read_chk(8'h00, 32'h0000_010F, "R3 set only enabled");

        // R8 set beats clear; also beats enable-write mask
        cycle(1, 8'h08, 32'h0000_0001, 17'h00001, "R8 clear vs event");
        read_chk(8'h00, 32'h0000_010F, "R8 event wins over clear");
        cycle(1, 8'h0C, 32'h0000_0000, 17'h00100, "R8 enable mask vs event");
        read_chk(8'h00, 32'h0000_0100, "R8 event wins over enable mask");

        // R9 flag offset read-only, aliases and hole read zero
        cycle(1, 8'h00, 32'h0, '0, "R9 flag write");
        read_chk(8'h00, 32'h0000_0100, "R9 flag write ignored");
        cycle(1, 8'h10, 32'hFFFF_FFFF, '0, "R9 hole write");
        read_chk(8'h0C, 32'h0000_010F, "R9 hole write ignored");
        read_chk(8'h04, 32'h0, "R9 set alias reads 0");
        read_chk(8'h08, 32'h0, "R9 clear alias reads 0");
        read_chk(8'h10, 32'h0, "R9 hole reads 0");

        // R10 upper bits
        cycle(1, 8'h0C, 32'hFFFF_FFFF, '0, "R10 enable all");
        read_chk(8'h0C, 32'h0001_FFFF, "R10 enable upper bits zero");
        cycle(0, 8'h00, 0, 17'h10000, "R11 device stop source");
        read_chk(8'h00, 32'h0001_0100, "R11 bit 16 is device stop");
        cycle(1, 8'h08, 32'hFFFF_FFFF, '0, "R4 clear all");
        read_chk(8'h00, 32'h0, "R4 all cleared");

        // random traffic with mid-run reset
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 5);
            a = (sel == 5) ? 8'h10 : 8'(sel * 4 % 16);
            if (i == 300) begin
                do_reset();
                read_chk(8'h0C, 32'h0, "R1 enable after mid reset");
            end
            cycle($urandom_range(0, 1) == 1, a,
                  ($urandom_range(0, 3) == 0) ? $urandom : ($urandom & 32'h0000_00FF),
                  NS'($urandom & (($urandom_range(0, 1) == 1) ? 32'h1FFFF : 32'hFF)),
                  "R7 random");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule